// File: doc/BRIEF.md
# Reaction Game Round Controller

This block runs the rounds of a reaction game. It has four target lamps, four push buttons and a twelve-position score bar. A prescaler turns the system clock into a slow tick enable. A reloadable down counter counts ticks to mark the end of each round. Between round ends, the block remembers which button the player pressed last.

When a round ends, the block compares the remembered button with the lit target and moves the score one position up or down. In the same cycle it steps a 15-bit pseudo-random shift generator, picks the next target from two of its bits, clears the remembered button, and reloads the round counter. The reload value comes from the new score: the base length at the lowest position, one fixed step shorter for each position above it. Play therefore speeds up as the player improves.

Everything runs on one clock. Slower rates exist only as clock enables. The buttons are assumed to be already debounced.

Top module: `rg_round_ctrl`

## Requirements
- R1: While reset is high and after it falls, `score_o` is 1 (lowest position, bit 0), `target_o` is 4'b0001 (target index 0) and `round_end_o` is 0 until the first round ends.
- R2: `target_o` is always one-hot, with bit k lit for target index k. At each round end the new index is {g[7], g[2]}, taken from the generator state g before it steps. The generator starts at `LFSR_SEED` and steps only at round ends to {g[13:0], g[14]^g[13]}. The all-zero state steps to 1.
- R3: A button press in any cycle is remembered as that button's index 0..3, replacing any earlier one. When several buttons are high in one cycle, the lowest index is taken. At a round end the memory is cleared to "no press", unless a button is high in that same cycle; such a press belongs to the next round.
- R4: `score_o` is always one-hot. At a round end it moves one bit toward the MSB if the remembered press matches the lit target index, and one bit toward the LSB otherwise (including when nothing was pressed). It stays put at bit NPOS-1 on a hit and at bit 0 on a miss.
- R5: A tick enable occurs once every `TICK_DIV` clock cycles. The first round lasts `BASE_TICKS` ticks, counted from reset release. Each later round lasts `BASE_TICKS - p*STEP_TICKS` ticks, where p is the score index set at the preceding round end.
- R6: `round_end_o` is high for exactly one cycle per round. Score and target change only in a cycle where `round_end_o` is high, and both already show their new values in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 4 | Debounced button levels, bit k is button k |
| target_o | output | 4 | One-hot lit target lamp |
| score_o | output | NPOS | One-hot score position, bit 0 is lowest |
| round_end_o | output | 1 | One-cycle pulse marking a round end |

## Verification
The hardest cases to reach from the ports are presses that land on the boundary between rounds. One is a button held in the very cycle the counter expires, which must count toward the next round and not the one being judged. Another is a correct press followed later by a wrong one in the same round. The bench tracks the tick phase and remaining count of an arithmetic model, so it can place presses at exact offsets, including the expiry cycle itself. It then climbs the score to the top stop and drives it down to the bottom stop, so that every round length in the table is measured.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int NTGT   = 4;
  localparam int CODE_W = 2;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  vld;
    code_t code;
  } press_t;
endpackage

// File: rtl/rg_tick_gen.sv
module rg_tick_gen #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pcnt_q;
      logic          wrap;

      assign wrap   = (pcnt_q == PW'(DIV - 1));
      assign tick_o = wrap;

      always_ff @(posedge clk) begin
        if (rst) pcnt_q <= '0;
        else if (wrap) pcnt_q <= '0;
        else pcnt_q <= pcnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rg_lfsr.sv
module rg_lfsr #(
  parameter int              W    = 15,
  parameter logic [W-1:0]    SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;
  logic         fb;

  assign fb      = (st_q == '0) ? 1'b1 : (st_q[W-1] ^ st_q[W-2]);
  assign state_o = st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEED;
    else if (step_i) st_q <= {st_q[W-2:0], fb};
  end
endmodule

// File: rtl/rg_period_lut.sv
module rg_period_lut #(
  parameter int NPOS  = 12,
  parameter int CNT_W = 12,
  parameter int BASE  = 2000,
  parameter int STEP  = 150
) (
  input  logic [$clog2(NPOS)-1:0] pos_i,
  output logic [CNT_W-1:0]        reload_o
);
  logic [CNT_W-1:0] tbl [NPOS];

  genvar gi;
  generate
    for (gi = 0; gi < NPOS; gi++) begin : g_ent
      assign tbl[gi] = CNT_W'(BASE - gi * STEP - 1);
    end
  endgenerate

  always_comb begin
    reload_o = tbl[0];
    for (int i = 0; i < NPOS; i++)
      if (pos_i == ($clog2(NPOS))'(i)) reload_o = tbl[i];
  end
endmodule

// File: rtl/rg_round_timer.sv
module rg_round_timer #(
  parameter int CNT_W = 12,
  parameter int INIT  = 1999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_W'(INIT);
    else if (tick_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/rg_round_ctrl.sv
module rg_round_ctrl #(
  parameter int                 NPOS       = 12,
  parameter int                 CNT_W      = 12,
  parameter int                 TICK_DIV   = 125000,
  parameter int                 BASE_TICKS = 2000,
  parameter int                 STEP_TICKS = 150,
  parameter int                 LFSR_W     = 15,
  parameter logic [LFSR_W-1:0]  LFSR_SEED  = 15'h1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [rg_pkg::NTGT-1:0] btn_i,
  output logic [rg_pkg::NTGT-1:0] target_o,
  output logic [NPOS-1:0]         score_o,
  output logic                    round_end_o
);
  import rg_pkg::*;

  localparam int POS_W  = $clog2(NPOS);
  localparam int TAP_HI = 7;
  localparam int TAP_LO = 2;

  logic              tick, expire;
  logic [LFSR_W-1:0] lfsr;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [CNT_W-1:0]  reload;
  code_t             tgt_q, tgt_d, press_code;
  logic              press_any, hit;
  press_t            cap_q;

  rg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  rg_round_timer #(.CNT_W(CNT_W), .INIT(BASE_TICKS - 1)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick), .reload_i(reload), .expire_o(expire)
  );

  rg_period_lut #(.NPOS(NPOS), .CNT_W(CNT_W), .BASE(BASE_TICKS), .STEP(STEP_TICKS)) u_lut (
    .pos_i(pos_d), .reload_o(reload)
  );

  rg_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step_i(expire), .state_o(lfsr)
  );

  always_comb begin
    press_code = '0;
    for (int i = NTGT - 1; i >= 0; i--)
      if (btn_i[i]) press_code = code_t'(i);
  end
  assign press_any = |btn_i;

  assign hit   = cap_q.vld && (cap_q.code == tgt_q);
  assign tgt_d = {lfsr[TAP_HI], lfsr[TAP_LO]};

  always_comb begin
    pos_d = pos_q;
    if (hit) begin
      if (pos_q != POS_W'(NPOS - 1)) pos_d = pos_q + 1'b1;
    end else begin
      if (pos_q != '0) pos_d = pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      score_o     <= NPOS'(1);
      tgt_q       <= '0;
      target_o    <= NTGT'(1);
      cap_q       <= '0;
      round_end_o <= 1'b0;
    end else begin
      round_end_o <= expire;
      if (expire) begin
        pos_q    <= pos_d;
        score_o  <= NPOS'(1) << pos_d;
        tgt_q    <= tgt_d;
        target_o <= NTGT'(1) << tgt_d;
      end
      if (press_any) cap_q <= '{vld: 1'b1, code: press_code};
      else if (expire) cap_q.vld <= 1'b0;
    end
  end
endmodule

// File: rtl/rg_round_ctrl_chk.sv
module rg_round_ctrl_chk #(
  parameter int NPOS = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      target_o,
  input logic [NPOS-1:0] score_o,
  input logic            round_end_o
);
  AST_SCORE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(score_o) == 1); // R4

  AST_TARGET_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(target_o) == 1); // R2

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    round_end_o |=> !round_end_o); // R6

  AST_SCORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !round_end_o |-> $stable(score_o)); // R6

  AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !round_end_o |-> $stable(target_o)); // R6

  AST_SCORE_STEP: assert property (@(posedge clk) disable iff (rst)
    round_end_o |-> ((score_o == ($past(score_o) << 1)) ||
                     (score_o == ($past(score_o) >> 1)) ||
                     ((score_o == $past(score_o)) && (score_o[0] || score_o[NPOS-1])))); // R4
endmodule

bind rg_round_ctrl rg_round_ctrl_chk #(.NPOS(NPOS)) u_chk (
  .clk(clk), .rst(rst), .target_o(target_o), .score_o(score_o), .round_end_o(round_end_o)
);

// File: tb/rg_round_ctrl_tb.sv
module rg_round_ctrl_tb;
  localparam int          NPOS  = 12;
  localparam int          DIV   = 2;
  localparam int          BASE  = 16;
  localparam int          STEP  = 1;
  localparam logic [14:0] SEED  = 15'h5A3C;
  localparam int          NRND  = 60;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0]      btn = '0;
  logic [3:0]      target_o;
  logic [NPOS-1:0] score_o;
  logic            round_end_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rg_round_ctrl #(
    .NPOS(NPOS), .CNT_W(12), .TICK_DIV(DIV), .BASE_TICKS(BASE),
    .STEP_TICKS(STEP), .LFSR_W(15), .LFSR_SEED(SEED)
  ) u_dut (
    .clk(clk), .rst(rst), .btn_i(btn), .target_o(target_o),
    .score_o(score_o), .round_end_o(round_end_o)
  );

  // arithmetic model state
  int          m_pcnt, m_cnt, m_pos, m_tgt, m_code, m_rounds;
  bit          m_vld, m_end;
  logic [14:0] m_g;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [3:0] b);
    bit tk, en, h;
    tk = (m_pcnt == DIV - 1);
    m_pcnt = tk ? 0 : m_pcnt + 1;
    en = tk && (m_cnt == 0);
    if (en) begin
      h = m_vld && (m_code == m_tgt);
      if (h) m_pos = (m_pos < NPOS - 1) ? m_pos + 1 : m_pos;
      else   m_pos = (m_pos > 0) ? m_pos - 1 : 0;
      m_tgt = {m_g[7], m_g[2]};
      m_g   = (m_g == 0) ? 15'h1 : {m_g[13:0], m_g[14] ^ m_g[13]};
      m_cnt = BASE - m_pos * STEP - 1;
      m_rounds++;
    end else if (tk) begin
      m_cnt = m_cnt - 1;
    end
    if (b != 0) begin
      m_vld = 1'b1;
      for (int i = 3; i >= 0; i--) if (b[i]) m_code = i;
    end else if (en) begin
      m_vld = 1'b0;
    end
    m_end = en;
  endtask

  function automatic int onehot_idx(input logic [NPOS-1:0] v);
    int r = -1;
    for (int i = 0; i < NPOS; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [3:0] pick_btn();
    bit at_end;
    logic [3:0] t, w;
    int k;
    at_end = (m_pcnt == DIV - 1) && (m_cnt == 0);
    t = 4'b0001 << m_tgt;
    w = 4'b0001 << ((m_tgt + 1) % 4);
    if (m_rounds < 14) begin            // R4 hits up to the top stop
      return (m_pcnt == 0 && m_cnt == 3) ? t : 4'b0;
    end else if (m_rounds < 30) begin   // R3 miss variants
      k = m_rounds % 4;
      if (k == 1 && m_pcnt == 0 && m_cnt == 3) return w;
      if (k == 2 && m_pcnt == 0 && m_cnt == 4) return t;
      if (k == 2 && m_pcnt == 0 && m_cnt == 2) return w;
      if (k == 3 && at_end) return t;
      return 4'b0;
    end else if (m_rounds < 42) begin   // R3 late correct press, simultaneous presses
      if (m_rounds % 2 == 0) begin
        if (m_pcnt == 0 && m_cnt == 4) return w;
        if (m_pcnt == 0 && m_cnt == 2) return t;
      end else if (m_pcnt == 0 && m_cnt == 3) begin
        return (m_tgt == 3) ? 4'b1000 : (t | 4'b1000);
      end
      return 4'b0;
    end
    return 4'b0;                        // R4 misses down to the bottom stop
  endfunction

  initial begin
    int since = 0;
    int prev_pos = -1;
    int exp_len;
    logic [3:0] b;

    m_pcnt = 0; m_cnt = BASE - 1; m_pos = 0; m_tgt = 0; m_code = 0;
    m_rounds = 0; m_vld = 1'b0; m_end = 1'b0; m_g = SEED;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(score_o == 1,      "R1 score in reset",  int'(score_o),  1);
    check(target_o == 4'b1,  "R1 target in reset", int'(target_o), 1);
    check(round_end_o == 0,  "R1 round_end in reset", int'(round_end_o), 0);
    rst = 1'b0;

    while (m_rounds < NRND) begin
      b = pick_btn();
      btn = b;
      @(posedge clk);
      model_step(b);
      @(negedge clk);
      since++;
      check(score_o == (NPOS'(1) << m_pos), "R4 score", onehot_idx(score_o), m_pos);
      check(target_o == (4'b1 << m_tgt),    "R2 target", int'(target_o), int'(4'b1 << m_tgt));
      check(round_end_o == m_end,           "R6 round_end", int'(round_end_o), int'(m_end));
      if (round_end_o) begin
        exp_len = (prev_pos < 0) ? BASE * DIV : (BASE - prev_pos * STEP) * DIV;
        check(since == exp_len, "R5 round length", since, exp_len);
        prev_pos = onehot_idx(score_o);
        since = 0;
      end
    end
    btn = '0;
    check(m_pos == 0, "R4 bottom stop reached", m_pos, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", m_rounds, NRND);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule